// File: doc/BRIEF.md
# Endian-Selectable Aligned Load/Store Unit

This block connects a 32-bit register datapath to a memory that is addressed in bytes but stored as 32-bit words split into four byte lanes (lane 0 is bits 7:0, lane 3 is bits 31:24). A request carries a byte address, an access size, a load or store command, a signed flag for loads, the store data, and a per-request endianness select. For a store, the unit places the data in the lanes the address selects and raises the matching byte enables. For a load, it pulls the selected lanes out of the returned word, right-justifies them and extends them to 32 bits.

The endianness select only changes which lane a byte address maps to. With little-endian order, byte offset k (address bits 1:0) sits in lane k. With big-endian order, it sits in lane 3-k. The first byte of a multi-byte value is its least significant byte in little-endian order and its most significant byte in big-endian order. An access whose address is not a multiple of its size is not sent to memory. It is answered with a fault instead.

A small controller sequences each request through four named states. ST_IDLE accepts a request. It moves to ST_ISSUE when the request is aligned and to ST_FAULT when it is not. ST_ISSUE drives the one-cycle memory request and always moves to ST_COMPLETE. ST_COMPLETE returns the response using the memory read data, which arrives one cycle after the request, and goes back to ST_IDLE. ST_FAULT returns a fault response and goes back to ST_IDLE.

Top module: `lsu_endian_unit`

## Requirements
- R1: A byte access (size code 0) enables exactly one lane. That lane is the address offset in little-endian mode (big_endian=0) and 3 minus the offset in big-endian mode (big_endian=1). The store byte is placed in that lane.
- R2: A halfword access (size code 1) at offset 0 or 2 enables two adjacent lanes. The byte at the lower address takes the low half of the store data in little-endian mode and the high half in big-endian mode.
- R3: A word access (size code 2) at offset 0 enables all four lanes. The byte at the word address holds bits 7:0 in little-endian mode and bits 31:24 in big-endian mode.
- R4: A load returns its bytes right-justified in rsp_rdata. The byte at the lowest address is least significant in little-endian mode and most significant in big-endian mode.
- R5: A byte or halfword load with req_signed=1 fills the upper bits with the loaded value's top bit. With req_signed=0 it fills them with zeros.
- R6: A halfword with address bit 0 set, a word with address bits 1:0 not both zero, or the reserved size code 3 produces a response with rsp_fault=1 in the cycle after acceptance. That access raises no memory request.
- R7: mem_addr always carries the request address with bits 1:0 forced to zero.
- R8: A request is accepted only in ST_IDLE while req_valid is high. An aligned request raises mem_req for exactly the cycle after acceptance, and rsp_valid follows one cycle later. busy is high from acceptance until the response cycle ends, and req_valid has no effect while busy is high.
- R9: After reset, mem_req, rsp_valid, rsp_fault and busy are all low.
- R10: A store response returns rsp_rdata equal to zero, and mem_we is high only together with mem_req for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend a load result |
| big_endian | input | 1 | 1 = big-endian lane order for this request |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| busy | output | 1 | Request in progress; new requests ignored |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word address, bits 1:0 zero |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-positioned store data |
| mem_rdata | input | 32 | Memory read word, valid the cycle after mem_req |
| rsp_valid | output | 1 | Response cycle |
| rsp_fault | output | 1 | Misaligned or reserved-size access |
| rsp_rdata | output | 32 | Extended load result, zero for stores |

## Verification
The assertions check the properties that hold on every cycle. The enable pattern always has one, two or four bits set. The memory address always has bits 1:0 at zero. A write is only issued together with a memory request. Every memory request is followed by a non-fault response. A misaligned halfword or word request always turns into a fault with no memory request. Accepting a request always raises busy. The actual lane chosen for each offset in each endianness, the byte order of the data, and the sign or zero extension depend on the data, so only the bench's scenarios can show them. The bench compares those results against its own byte-addressed memory model, across directed corner cases and random mixed traffic.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ISSUE    = 2'd1,
        ST_FAULT    = 2'd2,
        ST_COMPLETE = 2'd3
    } lsu_state_e;

endpackage

// File: rtl/lsu_align_check.sv
`timescale 1ns/1ps
module lsu_align_check
    import lsu_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   offset,
    output logic               misaligned
);

    logic [OFF_W-1:0] low_mask;

    always_comb begin
        low_mask = '0;
        unique case (size)
            SZ_BYTE: low_mask = '0;
            SZ_HALF: low_mask = OFF_W'(1);
            SZ_WORD: low_mask = OFF_W'(3);
            SZ_RSVD: low_mask = '1;
        endcase
    end

    always_comb begin
        misaligned = (size == SZ_RSVD) || ((offset & low_mask) != '0);
    end

endmodule

// File: rtl/lsu_lane_map.sv
`timescale 1ns/1ps
module lsu_lane_map
    import lsu_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_e          size,
    input  logic [OFF_W-1:0]   offset,
    input  logic               big,
    output logic [OFF_W-1:0]   shift,
    output logic [LANES-1:0]   byte_en
);

    int nbytes_i;
    int shift_i;

    always_comb begin
        nbytes_i = LANES;
        unique case (size)
            SZ_BYTE: nbytes_i = 1;
            SZ_HALF: nbytes_i = 2;
            SZ_WORD: nbytes_i = 4;
            SZ_RSVD: nbytes_i = LANES;
        endcase
    end

    always_comb begin
        if (big) begin
            shift_i = LANES - int'(offset) - nbytes_i;
        end else begin
            shift_i = int'(offset);
        end
        if (shift_i < 0) begin
            shift_i = 0;
        end
    end

    assign shift = OFF_W'(shift_i);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign byte_en[i] = (i >= shift_i) && (i < shift_i + nbytes_i);
    end

endmodule

// File: rtl/lsu_data_path.sv
`timescale 1ns/1ps
module lsu_data_path
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  acc_size_e          size,
    input  logic               sgn,
    input  logic [OFF_W-1:0]   shift,
    input  logic [DATA_W-1:0]  store_data,
    input  logic [DATA_W-1:0]  load_word,
    output logic [DATA_W-1:0]  lane_data,
    output logic [DATA_W-1:0]  load_result
);

    logic [DATA_W-1:0] shifted;

    assign lane_data = store_data << {shift, 3'b000};
    assign shifted   = load_word  >> {shift, 3'b000};

    always_comb begin
        load_result = shifted;
        unique case (size)
            SZ_BYTE: load_result = {{(DATA_W-8){sgn & shifted[7]}}, shifted[7:0]};
            SZ_HALF: load_result = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
            SZ_WORD: load_result = shifted;
            SZ_RSVD: load_result = '0;
        endcase
    end

endmodule

// File: rtl/lsu_ctrl.sv
`timescale 1ns/1ps
module lsu_ctrl
    import lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_bad,
    output lsu_state_e  state,
    output logic        accept,
    output logic        mem_req,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic        busy
);

    lsu_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = req_bad ? ST_FAULT : ST_ISSUE;
                end
            end
            ST_ISSUE:    state_nx = ST_COMPLETE;
            ST_COMPLETE: state_nx = ST_IDLE;
            ST_FAULT:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = (state == ST_IDLE) && req_valid;
        mem_req   = (state == ST_ISSUE);
        rsp_valid = (state == ST_COMPLETE) || (state == ST_FAULT);
        rsp_fault = (state == ST_FAULT);
        busy      = (state != ST_IDLE);
    end

endmodule

// File: rtl/lsu_endian_unit.sv
`timescale 1ns/1ps
module lsu_endian_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [1:0]         req_size,
    input  logic               req_signed,
    input  logic               big_endian,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [DATA_W-1:0]  rsp_rdata
);

    lsu_state_e         state;
    logic               accept;
    logic               in_bad;
    logic               issue;
    logic               store_q;
    acc_size_e          size_q;
    logic               sgn_q;
    logic               big_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [OFF_W-1:0]   shift;
    logic [LANES-1:0]   lane_en;
    logic [DATA_W-1:0]  lane_data;
    logic [DATA_W-1:0]  load_result;

    lsu_align_check #(.OFF_W(OFF_W)) u_align (
        .size       (acc_size_e'(req_size)),
        .offset     (req_addr[OFF_W-1:0]),
        .misaligned (in_bad)
    );

    lsu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bad   (in_bad),
        .state     (state),
        .accept    (accept),
        .mem_req   (issue),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .busy      (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            size_q  <= SZ_BYTE;
            sgn_q   <= 1'b0;
            big_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            store_q <= req_store;
            size_q  <= acc_size_e'(req_size);
            sgn_q   <= req_signed;
            big_q   <= big_endian;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    lsu_lane_map #(.LANES(LANES)) u_lanes (
        .size    (size_q),
        .offset  (addr_q[OFF_W-1:0]),
        .big     (big_q),
        .shift   (shift),
        .byte_en (lane_en)
    );

    lsu_data_path #(.DATA_W(DATA_W)) u_data (
        .size        (size_q),
        .sgn         (sgn_q),
        .shift       (shift),
        .store_data  (wdata_q),
        .load_word   (mem_rdata),
        .lane_data   (lane_data),
        .load_result (load_result)
    );

    always_comb begin
        mem_req   = issue;
        mem_we    = issue && store_q;
        mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_be    = issue ? lane_en : '0;
        mem_wdata = lane_data;
        rsp_rdata = ((state == ST_COMPLETE) && !store_q) ? load_result : '0;
    end

endmodule

// File: rtl/lsu_checker.sv
`timescale 1ns/1ps
module lsu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_size,
    input logic [31:0] req_addr,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        rsp_valid,
    input logic        rsp_fault
);

    p_be_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

    p_word_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_half_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_size == 2'd1 && req_addr[0]) |=> (rsp_fault && !mem_req));

    p_word_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_size == 2'd2 && req_addr[1:0] != 2'b00) |=> (rsp_fault && !mem_req));

    p_issue_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (rsp_valid && !rsp_fault && !mem_req));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_we_with_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    p_fault_is_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

endmodule

bind lsu_endian_unit lsu_checker u_lsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault)
);

// File: tb/lsu_endian_unit_bench.sv
`timescale 1ns/1ps
module lsu_endian_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic        big_endian = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, mem_req, mem_we, rsp_valid, rsp_fault;
    logic [31:0] mem_addr, mem_wdata, rsp_rdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;

    logic [31:0] mem_w [16];
    logic [7:0]  ref_b [64];

    always #2.5 clk = ~clk;

    lsu_endian_unit u_lsu_endian_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .big_endian(big_endian),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_rdata(rsp_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            for (int l = 0; l < 4; l++) begin
                if (mem_we && mem_be[l]) mem_w[mem_addr[5:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end
            mem_rdata <= mem_w[mem_addr[5:2]];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lane_of(input bit big, input int a);
        return big ? 3 - (a % 4) : (a % 4);
    endfunction

    function automatic int size_bytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit is_bad(input logic [1:0] sz, input int a);
        return (sz == 2'd3) || (sz == 2'd1 && (a % 2) != 0) || (sz == 2'd2 && (a % 4) != 0);
    endfunction

    // byte of the value that lands at address a+i
    function automatic logic [7:0] val_byte(input bit big, input int n, input int i, input logic [31:0] v);
        int k;
        k = big ? (n - 1 - i) : i;
        return v[k*8 +: 8];
    endfunction

    task automatic do_access(input bit st, input logic [1:0] sz, input bit sg, input bit bg,
                             input int a, input logic [31:0] wd, input bit noise);
        int n;
        logic [3:0]  ebe;
        logic [31:0] ewd, mask, eld;
        string tag;
        n = size_bytes(sz);
        tag = (sz == 2'd0) ? "R1" : (sz == 2'd1) ? "R2" : "R3";
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
        big_endian = bg; req_addr = a; req_wdata = wd;
        @(negedge clk);
        if (noise) begin
            req_store = ~st; req_addr = a ^ 32'h4; req_size = 2'd0; req_wdata = ~wd;
        end else begin
            req_valid = 1'b0;
        end
        if (is_bad(sz, a)) begin
            check(rsp_valid && rsp_fault, "R6", {30'd0, rsp_valid, rsp_fault}, 32'h3);
            check(!mem_req, "R6", {31'd0, mem_req}, 32'h0);
        end else begin
            ebe = '0; ewd = '0; mask = '0;
            for (int i = 0; i < n; i++) begin
                int ln;
                ln = lane_of(bg, a + i);
                ebe[ln] = 1'b1;
                mask[ln*8 +: 8] = 8'hFF;
                ewd[ln*8 +: 8] = val_byte(bg, n, i, wd);
            end
            check(mem_req && (mem_we == st), "R8", {30'd0, mem_req, mem_we}, {30'd0, 1'b1, st});
            check(mem_addr == (a & ~32'h3), "R7", mem_addr, a & ~32'h3);
            check(mem_be == ebe, tag, {28'd0, mem_be}, {28'd0, ebe});
            if (st) check((mem_wdata & mask) == ewd, tag, mem_wdata & mask, ewd);
            check(!rsp_valid, "R8", {31'd0, rsp_valid}, 32'h0);
            @(negedge clk);
            check(rsp_valid && !rsp_fault && !mem_req, "R8", {29'd0, rsp_valid, rsp_fault, mem_req}, 32'h4);
            if (st) begin
                check(rsp_rdata == 32'h0, "R10", rsp_rdata, 32'h0);
                for (int i = 0; i < n; i++)
                    ref_b[(a & ~3) + lane_of(bg, a + i)] = val_byte(bg, n, i, wd);
            end else begin
                eld = '0;
                for (int i = 0; i < n; i++) begin
                    logic [7:0] b;
                    b = ref_b[(a & ~3) + lane_of(bg, a + i)];
                    if (bg) eld = (eld << 8) | {24'd0, b};
                    else    eld = eld | ({24'd0, b} << (8 * i));
                end
                if (sg && n == 1) eld = {{24{eld[7]}}, eld[7:0]};
                if (sg && n == 2) eld = {{16{eld[15]}}, eld[15:0]};
                check(rsp_rdata == eld, (n < 4) ? "R5" : "R4", rsp_rdata, eld);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        check(!busy && !mem_req && !rsp_valid, "R8", {29'd0, busy, mem_req, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int w = 0; w < 16; w++) begin
            for (int l = 0; l < 4; l++) begin
                mem_w[w][l*8 +: 8] = 8'(w * 29 + l * 71 + 13);
                ref_b[w*4 + l]     = 8'(w * 29 + l * 71 + 13);
            end
        end
        repeat (3) @(negedge clk);
        check(!mem_req && !rsp_valid && !rsp_fault && !busy, "R9",
              {28'd0, mem_req, rsp_valid, rsp_fault, busy}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req, "R9", {30'd0, busy, mem_req}, 32'h0);

        // directed: bytes at every offset, both orders, signed and unsigned
        for (int bg = 0; bg < 2; bg++) begin
            for (int off = 0; off < 4; off++) begin
                do_access(1'b1, 2'd0, 1'b0, bit'(bg), 8 + off, 32'h80 + off, 1'b0);
                do_access(1'b0, 2'd0, 1'b1, bit'(bg), 8 + off, 32'h0, 1'b0);
                do_access(1'b0, 2'd0, 1'b0, bit'(bg), 8 + off, 32'h0, 1'b0);
            end
            do_access(1'b1, 2'd1, 1'b0, bit'(bg), 16, 32'h0000_A1B2, 1'b0);
            do_access(1'b1, 2'd1, 1'b0, bit'(bg), 18, 32'h0000_7C3D, 1'b0);
            do_access(1'b0, 2'd1, 1'b1, bit'(bg), 16, 32'h0, 1'b0);
            do_access(1'b0, 2'd1, 1'b0, bit'(bg), 16, 32'h0, 1'b0);
            do_access(1'b0, 2'd1, 1'b1, bit'(bg), 18, 32'h0, 1'b0);
            do_access(1'b1, 2'd2, 1'b0, bit'(bg), 20, 32'h1122_3344, 1'b0);
            do_access(1'b0, 2'd2, 1'b0, bit'(bg), 20, 32'h0, 1'b0);
            do_access(1'b0, 2'd2, 1'b0, bit'(bg), 16, 32'h0, 1'b0);
        end
        // directed: faults (R6) and ignored requests while busy (R8)
        do_access(1'b0, 2'd1, 1'b0, 1'b0, 5, 32'h0, 1'b0);
        do_access(1'b1, 2'd1, 1'b0, 1'b1, 7, 32'hFFFF, 1'b0);
        do_access(1'b1, 2'd2, 1'b0, 1'b0, 22, 32'hDEAD_BEEF, 1'b0);
        do_access(1'b0, 2'd2, 1'b0, 1'b1, 3, 32'h0, 1'b0);
        do_access(1'b0, 2'd2, 1'b0, 1'b0, 1, 32'h0, 1'b0);
        do_access(1'b1, 2'd3, 1'b0, 1'b0, 0, 32'h1234, 1'b0);
        do_access(1'b1, 2'd2, 1'b0, 1'b0, 28, 32'hCAFE_F00D, 1'b1);
        do_access(1'b0, 2'd2, 1'b0, 1'b0, 24, 32'h0, 1'b0);
        do_access(1'b0, 2'd2, 1'b0, 1'b0, 28, 32'h0, 1'b1);

        // random mixed traffic
        for (int t = 0; t < 600; t++) begin
            logic [1:0] sz;
            int a;
            sz = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) sz = 2'd3;
            else if (sz == 2'd3) sz = 2'd2;
            a = $urandom_range(0, 63);
            if ($urandom_range(0, 3) != 0) a = a & ~(size_bytes(sz) - 1);
            do_access(bit'($urandom_range(0, 1)), sz, bit'($urandom_range(0, 1)),
                      bit'($urandom_range(0, 1)), a, $urandom, bit'($urandom_range(0, 1)));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule